// File: doc/BRIEF.md
# Keccak-f[1600] Permutation Core with Rotated-Recompute Fault Check

This block applies the Keccak-f[1600] permutation to a 1600-bit state and checks its own arithmetic while doing so. The state is 25 lanes of 64 bits. Lane `x + 5*y` occupies bits `[64*(x+5*y) +: 64]`. With the usual sponge split, 576 bits are rate and 1024 bits are capacity. The core has one combinational round circuit (theta, rho with pi, chi, iota, each feeding the next) and one working register. A round counter picks the round constant.

After a start pulse, the core runs the full permutation on the plain input. It then runs it a second time on a copy in which every lane is rotated toward the least significant end by `ROT_N` bits. In that second pass the round constant is rotated by the same amount. The second result is rotated back and compared with the first. A difference means a fault hit one of the passes. The core then raises `done` for one cycle and presents the first-pass state together with a fault flag.

The surrounding sponge logic (padding, absorb, squeeze) lives outside. It may prepare the next block while the core is busy.

Top module: `kperm_rero`

## Requirements
- R1: Starting from an all-zero input state, the first five output lanes are F1258F7940E1DDE7, 84D5CCF933C0478A, D598261EA65AA9EE, BD1547306F80494D and 8B284E056253D057 (hex, lane 0 first).
- R2: For any input state, `state_out` after `done` equals Keccak-f[1600] (24 rounds) applied to that input, using the lane bit layout given above.
- R3: `done` is high for exactly one cycle. That cycle is 2*ROUNDS+1 clock edges (49 by default) after the edge that accepted `start`.
- R4: `busy` rises on the edge after `start` is accepted while idle. It stays high until `done` rises, and it is low whenever `done` is high.
- R5: A `start` pulse (with any `state_in`) that arrives while `busy` is high has no effect on the result or on the timing of the run in progress.
- R6: With no fault present, `fault` is 0 when `done` is high.
- R7: A single-bit corruption of the round result during either pass makes `fault` 1 when `done` is high. `fault` can only rise together with `done`.
- R8: A synchronous active-high `rst` clears `state_out`, `busy`, `done` and `fault` to 0 on the next edge, including in the middle of a run.
- R9: When idle, `state_out` and `fault` hold their values until the next accepted `start`. An accepted `start` clears `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a permutation; sampled only while idle |
| state_in | input | 1600 | Input state, sampled at the accepting edge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when result and flag are valid |
| fault | output | 1 | The two passes disagreed |
| state_out | output | 1600 | First-pass permuted state |

## Verification
A wrong round function, rho offset, lane mapping or round constant shows up at the ports as a wrong `state_out` lane once `done` arrives, 49 cycles after start. Such an error does not affect `fault`, so the reference comparison over many input patterns is what catches it. An error in the rotation equivalence (a wrong constant rotation or a mismatched rotate-back) makes `fault` rise on every fault-free run, so it is caught on the first run. Sequencing errors show directly as a wrong `done` latency, a wrong `done` width or a wrong `busy` window. Deliberately forced single-bit flips in each pass must reach `fault` within the same run.

// File: rtl/kperm_pkg.sv
package kperm_pkg;

    localparam int LANE_W  = 64;
    localparam int LANES   = 25;
    localparam int STATE_W = LANE_W * LANES;
    localparam int MAX_RND = 24;

    typedef logic [LANE_W-1:0]             lane_t;
    typedef logic [LANES-1:0][LANE_W-1:0]  state_t;
    typedef logic [MAX_RND-1:0][LANE_W-1:0] rc_tab_t;
    typedef logic [LANES-1:0][5:0]         rho_tab_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PLAIN,
        PH_ROT,
        PH_CMP
    } phase_e;

    // Rotate a lane toward the most significant end by k bits.
    function automatic lane_t rotl(input lane_t v, input int k);
        int kk;
        kk = k % LANE_W;
        if (kk == 0) return v;
        return (v << kk) | (v >> (LANE_W - kk));
    endfunction

    // Iota constants from the degree-8 LFSR, emitted in stream order.
    function automatic rc_tab_t build_rc();
        rc_tab_t    tab;
        logic [7:0] r;
        tab = '0;
        r   = 8'h01;
        for (int i = 0; i < MAX_RND; i++) begin
            for (int j = 0; j < 7; j++) begin
                tab[i][(1 << j) - 1] = r[0];
                r = {r[6:0], 1'b0} ^ (r[7] ? 8'h71 : 8'h00);
            end
        end
        return tab;
    endfunction

    // Per-lane rotation offsets, found by walking the (x,y) orbit.
    function automatic rho_tab_t build_rho();
        rho_tab_t tab;
        int x, y, nx;
        tab = '0;
        x = 1;
        y = 0;
        for (int t = 0; t < 24; t++) begin
            tab[5*y + x] = 6'(((t + 1) * (t + 2) / 2) % LANE_W);
            nx = y;
            y  = (2*x + 3*y) % 5;
            x  = nx;
        end
        return tab;
    endfunction

endpackage

// File: rtl/kperm_seq.sv
module kperm_seq
    import kperm_pkg::*;
#(
    parameter int ROUNDS = 24,
    localparam int CW    = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output phase_e        phase,
    output logic [CW-1:0] rnd,
    output logic          last_rnd
);

    assign last_rnd = (rnd == CW'(ROUNDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rnd   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    rnd <= '0;
                    if (start) phase <= PH_PLAIN;
                end
                PH_PLAIN: begin
                    if (last_rnd) begin
                        phase <= PH_ROT;
                        rnd   <= '0;
                    end else begin
                        rnd <= rnd + 1'b1;
                    end
                end
                PH_ROT: begin
                    if (last_rnd) begin
                        phase <= PH_CMP;
                        rnd   <= '0;
                    end else begin
                        rnd <= rnd + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/kperm_round.sv
module kperm_round
    import kperm_pkg::*;
(
    input  state_t st_i,
    input  lane_t  rc_i,
    output state_t st_o
);

    localparam rho_tab_t RHO = build_rho();

    lane_t  colpar [5];
    lane_t  mixd   [5];
    state_t perm;

    // theta: column parities and their mix
    for (genvar x = 0; x < 5; x++) begin : g_col
        assign colpar[x] = st_i[x] ^ st_i[x+5] ^ st_i[x+10] ^ st_i[x+15] ^ st_i[x+20];
    end
    for (genvar x = 0; x < 5; x++) begin : g_mix
        assign mixd[x] = colpar[(x+4)%5] ^ rotl(colpar[(x+1)%5], 1);
    end

    // rho + pi: rotate each lane, then move it to (y, 2x+3y)
    for (genvar y = 0; y < 5; y++) begin : g_py
        for (genvar x = 0; x < 5; x++) begin : g_px
            localparam int SRC = 5*y + x;
            localparam int DST = 5*((2*x + 3*y) % 5) + y;
            assign perm[DST] = rotl(st_i[SRC] ^ mixd[x], int'(RHO[SRC]));
        end
    end

    // chi, with iota folded into lane 0
    for (genvar y = 0; y < 5; y++) begin : g_cy
        for (genvar x = 0; x < 5; x++) begin : g_cx
            localparam int IDX = 5*y + x;
            lane_t nl;
            assign nl = perm[IDX] ^ (~perm[5*y + (x+1)%5] & perm[5*y + (x+2)%5]);
            if (IDX == 0) begin : g_iota
                assign st_o[IDX] = nl ^ rc_i;
            end else begin : g_plain
                assign st_o[IDX] = nl;
            end
        end
    end

endmodule

// File: rtl/kperm_lane_rot.sv
module kperm_lane_rot
    import kperm_pkg::*;
#(
    parameter int SHIFT  = 13,
    parameter bit TO_LSB = 1'b1
) (
    input  state_t d,
    output state_t q
);

    localparam int LEFT = TO_LSB ? (LANE_W - (SHIFT % LANE_W)) % LANE_W : SHIFT % LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign q[i] = rotl(d[i], LEFT);
    end

endmodule

// File: rtl/kperm_rero.sv
module kperm_rero
    import kperm_pkg::*;
#(
    parameter int ROUNDS = 24,
    parameter int ROT_N  = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [STATE_W-1:0] state_in,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [STATE_W-1:0] state_out
);

    localparam int      CW      = $clog2(ROUNDS);
    localparam int      RC_BASE = MAX_RND - ROUNDS;
    localparam rc_tab_t RC_TAB  = build_rc();

    phase_e        phase;
    logic [CW-1:0] rnd;
    logic          last_rnd;

    state_t work_q;     // round register shared by both passes
    state_t ref_q;      // input during pass one, first-pass result after
    state_t ref_rot;    // R(input)
    state_t work_back;  // R^-1(second-pass result)
    state_t rnd_nxt;
    logic   done_q;
    logic   fault_q;

    logic [4:0] rc_idx;
    lane_t      rc_plain;
    lane_t      rc_use;

    kperm_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .phase    (phase),
        .rnd      (rnd),
        .last_rnd (last_rnd)
    );

    assign rc_idx   = 5'(RC_BASE) + 5'(rnd);
    assign rc_plain = RC_TAB[rc_idx];
    assign rc_use   = (phase == PH_ROT) ? rotl(rc_plain, LANE_W - ROT_N) : rc_plain;

    kperm_round u_round (
        .st_i (work_q),
        .rc_i (rc_use),
        .st_o (rnd_nxt)
    );

    kperm_lane_rot #(.SHIFT(ROT_N), .TO_LSB(1'b1)) u_fwd (
        .d (ref_q),
        .q (ref_rot)
    );

    kperm_lane_rot #(.SHIFT(ROT_N), .TO_LSB(1'b0)) u_back (
        .d (work_q),
        .q (work_back)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= '0;
            ref_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        work_q  <= state_in;
                        ref_q   <= state_in;
                        fault_q <= 1'b0;
                    end
                end
                PH_PLAIN: begin
                    if (last_rnd) begin
                        ref_q  <= rnd_nxt;
                        work_q <= ref_rot;
                    end else begin
                        work_q <= rnd_nxt;
                    end
                end
                PH_ROT: work_q <= rnd_nxt;
                default: begin
                    done_q  <= 1'b1;
                    fault_q <= (work_back != ref_q);
                end
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign done      = done_q;
    assign fault     = fault_q;
    assign state_out = ref_q;

endmodule

// File: rtl/kperm_rero_chk.sv
module kperm_rero_chk #(
    parameter int ROUNDS = 24
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [1599:0] state_out
);

    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == 2*ROUNDS + 1));  // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R4
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);  // R4
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> done);  // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(state_out) && $stable(fault)));  // R9

endmodule

bind kperm_rero kperm_rero_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .state_out (state_out)
);

// File: tb/kperm_rero_bench.sv
`timescale 1ns/1ps
module kperm_rero_bench;

    localparam int ROUNDS = 24;
    localparam int LAT    = 2*ROUNDS + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1599:0] state_in = '0;
    logic          busy, done, fault;
    logic [1599:0] state_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [63:0] rcv [24];

    always #2.5 clk = ~clk;

    kperm_rero #(.ROUNDS(ROUNDS), .ROT_N(13)) u_kperm_rero (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .state_in  (state_in),
        .busy      (busy),
        .done      (done),
        .fault     (fault),
        .state_out (state_out)
    );

    function automatic logic [63:0] rol(input logic [63:0] v, input int k);
        if (k % 64 == 0) return v;
        return (v << (k % 64)) | (v >> (64 - (k % 64)));
    endfunction

    function automatic bit lfsr_bit(input int t);
        logic [8:0] r;
        if (t % 255 == 0) return 1'b1;
        r = 9'd1;
        for (int i = 1; i <= t % 255; i++) begin
            r = {r[7:0], 1'b0};
            if (r[8]) r = r ^ 9'h171;
        end
        return r[0];
    endfunction

    // Independent reference of the permutation on a 5x5 lane grid.
    function automatic logic [1599:0] ref_perm(input logic [1599:0] s);
        logic [63:0] a [5][5];
        logic [63:0] b [5][5];
        logic [63:0] c [5];
        logic [63:0] d [5];
        int off [5][5];
        int x, y, nx;
        logic [1599:0] o;
        off[0][0] = 0;
        x = 1; y = 0;
        for (int t = 0; t < 24; t++) begin
            off[x][y] = ((t+1)*(t+2)/2) % 64;
            nx = y; y = (2*x + 3*y) % 5; x = nx;
        end
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                a[i][j] = s[64*(i + 5*j) +: 64];
        for (int r = 0; r < 24; r++) begin
            for (int i = 0; i < 5; i++) c[i] = a[i][0]^a[i][1]^a[i][2]^a[i][3]^a[i][4];
            for (int i = 0; i < 5; i++) d[i] = c[(i+4)%5] ^ rol(c[(i+1)%5], 1);
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    b[j][(2*i+3*j)%5] = rol(a[i][j] ^ d[i], off[i][j]);
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    a[i][j] = b[i][j] ^ (~b[(i+1)%5][j] & b[(i+2)%5][j]);
            a[0][0] = a[0][0] ^ rcv[r];
        end
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                o[64*(i + 5*j) +: 64] = a[i][j];
        return o;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [1599:0] act, input logic [1599:0] exp);
        int bad_lane;
        bad_lane = -1;
        for (int i = 24; i >= 0; i--)
            if (act[64*i +: 64] !== exp[64*i +: 64]) bad_lane = i;
        n_chk++;
        if (bad_lane >= 0) begin
            n_bad++;
            $display("FAIL %s lane %0d: actual %h expected %h", req, bad_lane,
                     act[64*bad_lane +: 64], exp[64*bad_lane +: 64]);
        end
    endtask

    // Run one permutation; optional forced flip at negedge inj, optional start poke.
    task automatic run(input logic [1599:0] s, input int inj, input bit poke,
                       output logic [1599:0] res, output logic flt,
                       output int lat, output int dwidth);
        logic [1599:0] corrupt;
        lat = -1; dwidth = 0; res = '0; flt = 1'b0;
        @(negedge clk);
        state_in = s;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 200; c++) begin
            @(negedge clk);
            if (poke && c == 10) begin start = 1'b1; state_in = ~s; end
            if (poke && c == 11) begin start = 1'b0; state_in = s; end
            if (done) begin
                lat = c;
                res = state_out;
                flt = fault;
                @(negedge clk);
                dwidth = done ? 2 : 1;
                break;
            end
            if (c == inj) begin
                corrupt = u_kperm_rero.rnd_nxt ^ (1600'b1 << (64*7 + 19));
                force u_kperm_rero.rnd_nxt = corrupt;
                @(posedge clk);
                #1;
                release u_kperm_rero.rnd_nxt;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1599:0] res, pat, exp, held;
        logic          flt, held_f;
        int            lat, dw;
        logic [63:0]   seed;

        for (int i = 0; i < 24; i++) begin
            rcv[i] = '0;
            for (int j = 0; j < 7; j++) rcv[i][(1 << j) - 1] = lfsr_bit(j + 7*i);
        end

        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "state_out", state_out[63:0] | state_out[1599:1536], 64'd0);
        check("R8", "busy",  64'(busy),  64'd0);
        check("R8", "done",  64'(done),  64'd0);
        check("R8", "fault", 64'(fault), 64'd0);
        rst = 1'b0;

        // R1: all-zero input against known lanes
        run('0, -1, 1'b0, res, flt, lat, dw);
        check("R1", "lane0", res[0*64 +: 64], 64'hF1258F7940E1DDE7);
        check("R1", "lane1", res[1*64 +: 64], 64'h84D5CCF933C0478A);
        check("R1", "lane2", res[2*64 +: 64], 64'hD598261EA65AA9EE);
        check("R1", "lane3", res[3*64 +: 64], 64'hBD1547306F80494D);
        check("R1", "lane4", res[4*64 +: 64], 64'h8B284E056253D057);
        check_state("R2", res, ref_perm('0));
        check("R3", "latency", 64'(lat), 64'(LAT));
        check("R3", "done width", 64'(dw), 64'd1);
        check("R6", "fault", 64'(flt), 64'd0);

        // R9: outputs hold while idle
        held = state_out; held_f = fault;
        repeat (8) @(negedge clk);
        check_state("R9", state_out, held);
        check("R9", "fault hold", 64'(fault), 64'(held_f));

        // R2/R6: single-bit sweep, one per lane, plus dense patterns
        for (int ln = 0; ln < 25; ln++) begin
            pat = '0;
            pat[64*ln + (ln*41) % 64] = 1'b1;
            run(pat, -1, 1'b0, res, flt, lat, dw);
            check_state("R2", res, ref_perm(pat));
            check("R6", "fault", 64'(flt), 64'd0);
            check("R3", "latency", 64'(lat), 64'(LAT));
        end
        seed = 64'h0123456789ABCDEF;
        for (int k = 0; k < 6; k++) begin
            for (int ln = 0; ln < 25; ln++) begin
                seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
                pat[64*ln +: 64] = (k == 0) ? '1 : (k == 1) ? {16{4'hA}} : seed;
            end
            run(pat, -1, 1'b0, res, flt, lat, dw);
            check_state("R2", res, ref_perm(pat));
            check("R6", "fault", 64'(flt), 64'd0);
        end

        // R5: start during busy is ignored
        pat = '0;
        for (int ln = 0; ln < 25; ln++) pat[64*ln +: 64] = 64'(ln) * 64'h1111;
        run(pat, -1, 1'b1, res, flt, lat, dw);
        check_state("R5", res, ref_perm(pat));
        check("R5", "latency", 64'(lat), 64'(LAT));

        // R7: flip in the plain pass
        run(pat, 5, 1'b0, res, flt, lat, dw);
        check("R7", "fault plain pass", 64'(flt), 64'd1);
        check("R3", "latency", 64'(lat), 64'(LAT));
        // R9: fault holds while idle
        repeat (5) @(negedge clk);
        check("R9", "fault held", 64'(fault), 64'd1);
        // R7: flip in the rotated pass; first-pass output intact
        run(pat, 30, 1'b0, res, flt, lat, dw);
        check("R7", "fault rotated pass", 64'(flt), 64'd1);
        check_state("R7", res, ref_perm(pat));
        // R9: next accepted start clears the flag
        run(pat, -1, 1'b0, res, flt, lat, dw);
        check("R9", "fault cleared", 64'(flt), 64'd0);

        // R8: reset mid-run
        @(negedge clk);
        state_in = pat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8", "busy mid", 64'(busy), 64'd0);
        check_state("R8", state_out, '0);
        check("R8", "done mid", 64'(done), 64'd0);
        rst = 1'b0;
        run('0, -1, 1'b0, res, flt, lat, dw);
        check("R1", "lane0 after reset", res[63:0], 64'hF1258F7940E1DDE7);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule